// File: doc/BRIEF.md
# Plasma panel subfield drive sequencer

This block produces the control timing for a plasma panel that separates addressing from display. Each frame is cut into binary-weighted subfields, one per bit of the pixel grey value. Every subfield opens with a fixed-length reset ramp enable, then addresses the panel rows one at a time, then issues alternating X and Y sustain enables whose count follows the subfield weight. Only cells written during addressing light during sustain, so the sum of the lit subfields reproduces the grey level.

Row data comes from an external line buffer. The block raises a request with a row index, and the buffer answers in the same cycle with one grey value per column. For subfield k the block slices out bit k of every pixel and drives it on the column outputs while the row's scan strobe is active. The number of sustain pulse pairs is the weight 2^k multiplied by a base count, which is sampled when the frame starts. Subfields run from the heaviest weight to the lightest.

Top module: `pdp_sf_seq`

## Requirements
- R1: While no frame is running every output is 0, including busy_o. The reset state is this idle state. A frame_start_i seen high at a clock edge while idle makes busy_o high from the next cycle. busy_o stays high through the last sustain cycle of the final subfield and drops on the cycle after it.
- R2: A frame contains PIX_W subfields. They are issued for bit PIX_W-1 first, down to bit 0. Each subfield runs its reset, address and sustain phases in that order.
- R3: Every subfield starts with reset_en_o high for exactly RESET_LEN consecutive cycles. The first of these cycles is the cycle after the frame start, or the cycle after the previous subfield ends.
- R4: The address phase visits rows 0 to LINES-1 in ascending order. For each row there is one cycle with line_req_o=1 and line_idx_o=row. It is followed by SCAN_W cycles in which scan_o has only bit row set and line_idx_o still equals row. line_idx_o is 0 outside the address phase.
- R5: During a row's scan cycles, col_o[c] equals bit k of line_pix_i[c*PIX_W +: PIX_W] as sampled in that row's request cycle, where k is the current subfield bit. col_o is 0 whenever scan_o is 0.
- R6: The sustain phase of subfield k contains base*2^k pulse pairs, where base is the sampled base count. Each pair is SUS_HALF cycles with sus_x_o=1, then SUS_HALF cycles with sus_y_o=1. The two are never high together. If base is 0 the sustain phase is skipped.
- R7: base_cnt_i is sampled only at frame start. Changes to it during a frame do not alter that frame's sustain lengths.
- R8: A frame_start_i pulse while busy_o is high is ignored. The running frame keeps its timing and length, and no new frame follows from that pulse.
- R9: In any cycle at most one of these is active: reset_en_o, line_req_o, any bit of scan_o, or either sustain enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Frame start strobe, honoured only when idle |
| base_cnt_i | input | BASE_W | Sustain pairs per weight unit, sampled at frame start |
| line_pix_i | input | COLS*PIX_W | Row grey values from the line buffer, valid in the request cycle |
| line_req_o | output | 1 | Row request to the line buffer |
| line_idx_o | output | $clog2(LINES) | Current row index during addressing |
| reset_en_o | output | 1 | Reset ramp enable |
| scan_o | output | LINES | One-hot scan strobe |
| col_o | output | COLS | Column address data for the current subfield bit |
| sus_x_o | output | 1 | X-electrode sustain enable |
| sus_y_o | output | 1 | Y-electrode sustain enable |
| busy_o | output | 1 | Frame in progress |

## Verification
The checker watches every cycle for the following: silent outputs while idle, a reset enable right after an accepted start, a one-hot scan strobe that always follows a request, columns gated to scan cycles, X/Y exclusion, and exclusion between phases. Several properties are beyond those per-cycle rules: the descending subfield order, the exact phase lengths, the per-row bit slicing and the weight-scaled pair counts. Only the bench's cycle-by-cycle scoreboard can show these. It also shows that a mid-frame start pulse or a base count change leaves the frame unchanged, by comparing every cycle and the total busy length against the expected schedule.

// File: rtl/pdp_sf_pkg.sv
package pdp_sf_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RESET,
    PH_REQ,
    PH_SCAN,
    PH_SUS
  } phase_e;
endpackage

// File: rtl/pdp_sf_ctrl.sv
module pdp_sf_ctrl
  import pdp_sf_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int LINES     = 480,
  parameter int BASE_W    = 4,
  parameter int RESET_LEN = 64,
  parameter int SCAN_W    = 8,
  parameter int SUS_HALF  = 12,
  localparam int LW  = $clog2(LINES),
  localparam int SFW = $clog2(PIX_W),
  localparam int MAXC = (RESET_LEN > SCAN_W) ?
                        ((RESET_LEN > SUS_HALF) ? RESET_LEN : SUS_HALF) :
                        ((SCAN_W > SUS_HALF) ? SCAN_W : SUS_HALF),
  localparam int CW  = $clog2(MAXC + 1),
  localparam int PW  = BASE_W + PIX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BASE_W-1:0] base_i,
  output phase_e            phase_o,
  output logic [LW-1:0]     line_o,
  output logic [SFW-1:0]    sf_o,
  output logic              y_half_o
);

  phase_e              phase_q, phase_d;
  logic [CW-1:0]       cnt_q, cnt_d;
  logic [LW-1:0]       line_q, line_d;
  logic [SFW-1:0]      sf_q, sf_d;
  logic [BASE_W-1:0]   base_q, base_d;
  logic [PW-1:0]       pair_q, pair_d;
  logic                yph_q, yph_d;
  logic [PW-1:0]       pair_last;

  assign pair_last = (PW'(base_q) << sf_q) - PW'(1);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    line_d  = line_q;
    sf_d    = sf_q;
    base_d  = base_q;
    pair_d  = pair_q;
    yph_d   = yph_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_d = PH_RESET;
          sf_d    = SFW'(PIX_W - 1);
          base_d  = base_i;
          cnt_d   = '0;
        end
      end
      PH_RESET: begin
        if (cnt_q == CW'(RESET_LEN - 1)) begin
          cnt_d   = '0;
          line_d  = '0;
          phase_d = PH_REQ;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      PH_REQ: begin
        phase_d = PH_SCAN;
        cnt_d   = '0;
      end
      PH_SCAN: begin
        if (cnt_q == CW'(SCAN_W - 1)) begin
          cnt_d = '0;
          if (line_q == LW'(LINES - 1)) begin
            line_d = '0;
            pair_d = '0;
            yph_d  = 1'b0;
            if (base_q != '0) begin
              phase_d = PH_SUS;
            end else if (sf_q == '0) begin
              phase_d = PH_IDLE;
            end else begin
              sf_d    = sf_q - SFW'(1);
              phase_d = PH_RESET;
            end
          end else begin
            line_d  = line_q + LW'(1);
            phase_d = PH_REQ;
          end
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      PH_SUS: begin
        if (cnt_q == CW'(SUS_HALF - 1)) begin
          cnt_d = '0;
          if (!yph_q) begin
            yph_d = 1'b1;
          end else begin
            yph_d = 1'b0;
            if (pair_q == pair_last) begin
              pair_d = '0;
              if (sf_q == '0) begin
                phase_d = PH_IDLE;
              end else begin
                sf_d    = sf_q - SFW'(1);
                phase_d = PH_RESET;
              end
            end else begin
              pair_d = pair_q + PW'(1);
            end
          end
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      line_q  <= '0;
      sf_q    <= '0;
      base_q  <= '0;
      pair_q  <= '0;
      yph_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      line_q  <= line_d;
      sf_q    <= sf_d;
      base_q  <= base_d;
      pair_q  <= pair_d;
      yph_q   <= yph_d;
    end
  end

  assign phase_o  = phase_q;
  assign line_o   = line_q;
  assign sf_o     = sf_q;
  assign y_half_o = yph_q;

endmodule

// File: rtl/pdp_sf_colsel.sv
module pdp_sf_colsel #(
  parameter int COLS  = 16,
  parameter int PIX_W = 8,
  localparam int SFW = $clog2(PIX_W)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [SFW-1:0]        sf_i,
  input  logic [COLS*PIX_W-1:0] pix_i,
  output logic [COLS-1:0]       col_o
);

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [PIX_W-1:0] px;
    assign px = pix_i[c*PIX_W +: PIX_W];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     col_o[c] <= 1'b0;
      else if (load_i) col_o[c] <= px[sf_i];
    end
  end

endmodule

// File: rtl/pdp_sf_scan_dec.sv
module pdp_sf_scan_dec #(
  parameter int LINES = 480,
  localparam int LW = $clog2(LINES)
) (
  input  logic             en_i,
  input  logic [LW-1:0]    line_i,
  output logic [LINES-1:0] scan_o
);

  for (genvar l = 0; l < LINES; l++) begin : g_row
    assign scan_o[l] = en_i && (line_i == LW'(l));
  end

endmodule

// File: rtl/pdp_sf_seq.sv
module pdp_sf_seq
  import pdp_sf_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int LINES     = 480,
  parameter int COLS      = 16,
  parameter int BASE_W    = 4,
  parameter int RESET_LEN = 64,
  parameter int SCAN_W    = 8,
  parameter int SUS_HALF  = 12,
  localparam int LW  = $clog2(LINES),
  localparam int SFW = $clog2(PIX_W)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  frame_start_i,
  input  logic [BASE_W-1:0]     base_cnt_i,
  input  logic [COLS*PIX_W-1:0] line_pix_i,
  output logic                  line_req_o,
  output logic [LW-1:0]         line_idx_o,
  output logic                  reset_en_o,
  output logic [LINES-1:0]      scan_o,
  output logic [COLS-1:0]       col_o,
  output logic                  sus_x_o,
  output logic                  sus_y_o,
  output logic                  busy_o
);

  phase_e         phase;
  logic [LW-1:0]  line;
  logic [SFW-1:0] sf;
  logic           y_half;
  logic [COLS-1:0] col_q;
  logic           in_scan;

  pdp_sf_ctrl #(
    .PIX_W(PIX_W), .LINES(LINES), .BASE_W(BASE_W),
    .RESET_LEN(RESET_LEN), .SCAN_W(SCAN_W), .SUS_HALF(SUS_HALF)
  ) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (frame_start_i),
    .base_i   (base_cnt_i),
    .phase_o  (phase),
    .line_o   (line),
    .sf_o     (sf),
    .y_half_o (y_half)
  );

  // row data is captured in the request cycle, shown during scan
  pdp_sf_colsel #(.COLS(COLS), .PIX_W(PIX_W)) u_colsel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (phase == PH_REQ),
    .sf_i   (sf),
    .pix_i  (line_pix_i),
    .col_o  (col_q)
  );

  assign in_scan = (phase == PH_SCAN);

  pdp_sf_scan_dec #(.LINES(LINES)) u_dec (
    .en_i   (in_scan),
    .line_i (line),
    .scan_o (scan_o)
  );

  assign reset_en_o = (phase == PH_RESET);
  assign line_req_o = (phase == PH_REQ);
  assign line_idx_o = (line_req_o || in_scan) ? line : '0;
  assign col_o      = in_scan ? col_q : '0;
  assign sus_x_o    = (phase == PH_SUS) && !y_half;
  assign sus_y_o    = (phase == PH_SUS) && y_half;
  assign busy_o     = (phase != PH_IDLE);

endmodule

// File: rtl/pdp_sf_seq_chk.sv
module pdp_sf_seq_chk #(
  parameter int LINES = 480,
  parameter int COLS  = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_start_i,
  input logic             busy_o,
  input logic             reset_en_o,
  input logic             line_req_o,
  input logic [LINES-1:0] scan_o,
  input logic [COLS-1:0]  col_o,
  input logic             sus_x_o,
  input logic             sus_y_o
);

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!reset_en_o && !line_req_o && scan_o == '0 && col_o == '0 &&
                 !sus_x_o && !sus_y_o));

  assert_start_reset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && frame_start_i) |=> (busy_o && reset_en_o));

  assert_scan_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(scan_o));

  assert_req_then_scan_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_req_o |=> (scan_o != '0));

  assert_col_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_o == '0) |-> (col_o == '0));

  assert_xy_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sus_x_o && sus_y_o));

  assert_phase_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({reset_en_o, line_req_o, |scan_o, sus_x_o | sus_y_o}) <= 1);

endmodule

bind pdp_sf_seq pdp_sf_seq_chk #(.LINES(LINES), .COLS(COLS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_start_i (frame_start_i),
  .busy_o        (busy_o),
  .reset_en_o    (reset_en_o),
  .line_req_o    (line_req_o),
  .scan_o        (scan_o),
  .col_o         (col_o),
  .sus_x_o       (sus_x_o),
  .sus_y_o       (sus_y_o)
);

// File: tb/sim_pdp_sf_seq.sv
`timescale 1ns/1ps
module sim_pdp_sf_seq;
  localparam int PIX_W = 8, LINES = 4, COLS = 4, BASE_W = 4;
  localparam int RESET_LEN = 3, SCAN_W = 2, SUS_HALF = 2;
  localparam int LW = $clog2(LINES);

  typedef struct packed {
    logic             busy;
    logic             rst;
    logic             req;
    logic [LW-1:0]    idx;
    logic [LINES-1:0] scan;
    logic [COLS-1:0]  col;
    logic             sx;
    logic             sy;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, fs = 1'b0;
  logic [BASE_W-1:0] base_cnt = '0;
  logic [COLS*PIX_W-1:0] pix;
  logic line_req, reset_en, sus_x, sus_y, busy;
  logic [LW-1:0] line_idx;
  logic [LINES-1:0] scan;
  logic [COLS-1:0] col;
  int seed = 0;
  int n_chk = 0, n_fail = 0, busy_len = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  function automatic logic [7:0] pix_val(input int l, input int c, input int s);
    return 8'(l * 53 + c * 29 + s * 71 + 5);
  endfunction

  for (genvar c = 0; c < COLS; c++) begin : g_buf
    assign pix[c*PIX_W +: PIX_W] = pix_val(int'(line_idx), c, seed);
  end

  pdp_sf_seq #(
    .PIX_W(PIX_W), .LINES(LINES), .COLS(COLS), .BASE_W(BASE_W),
    .RESET_LEN(RESET_LEN), .SCAN_W(SCAN_W), .SUS_HALF(SUS_HALF)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs), .base_cnt_i(base_cnt),
    .line_pix_i(pix), .line_req_o(line_req), .line_idx_o(line_idx),
    .reset_en_o(reset_en), .scan_o(scan), .col_o(col),
    .sus_x_o(sus_x), .sus_y_o(sus_y), .busy_o(busy)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int frame_len(input int base);
    int t = 0;
    for (int k = 0; k < PIX_W; k++)
      t += RESET_LEN + LINES * (1 + SCAN_W) + 2 * SUS_HALF * (base << k);
    return t;
  endfunction

  // monitor: compare every cycle against the expected schedule
  initial begin
    forever begin
      exp_t e;
      @(posedge clk); #1;
      e = (q.size() > 0) ? q.pop_front() : '0;
      if (busy) busy_len++;
      if (busy !== e.busy)
        check(0, "R1 busy", longint'(busy), longint'(e.busy));
      else if (reset_en !== e.rst)
        check(0, "R3 reset_en", longint'(reset_en), longint'(e.rst));
      else if (line_req !== e.req || line_idx !== e.idx)
        check(0, "R4 req/idx", longint'({line_req, line_idx}), longint'({e.req, e.idx}));
      else if (scan !== e.scan)
        check(0, "R4 scan", longint'(scan), longint'(e.scan));
      else if (col !== e.col)
        check(0, "R5 col", longint'(col), longint'(e.col));
      else if (sus_x !== e.sx || sus_y !== e.sy)
        check(0, "R6 sustain (R2 order)", longint'({sus_x, sus_y}), longint'({e.sx, e.sy}));
      else
        check(1, "", 0, 0);
      check($countones({reset_en, line_req, |scan, sus_x | sus_y}) <= 1, "R9 phase overlap",
            longint'({reset_en, line_req, |scan, sus_x, sus_y}), 0);
    end
  end

  // driver: starts a frame and pushes its expected cycle schedule
  task automatic run_frame(input int base, input int s, input int poke_at,
                           input int new_base, input string tag);
    @(negedge clk);
    seed = s;
    base_cnt = BASE_W'(base);
    busy_len = 0;
    fs = 1'b1;
    for (int k = PIX_W - 1; k >= 0; k--) begin
      exp_t e;
      for (int i = 0; i < RESET_LEN; i++) begin
        e = '0; e.busy = 1; e.rst = 1; q.push_back(e);
      end
      for (int l = 0; l < LINES; l++) begin
        logic [COLS-1:0] cv;
        for (int c = 0; c < COLS; c++) begin
          logic [7:0] p;
          p = pix_val(l, c, s);
          cv[c] = p[k];
        end
        e = '0; e.busy = 1; e.req = 1; e.idx = LW'(l); q.push_back(e);
        for (int i = 0; i < SCAN_W; i++) begin
          e = '0; e.busy = 1; e.idx = LW'(l); e.scan = LINES'(1) << l; e.col = cv;
          q.push_back(e);
        end
      end
      for (int p = 0; p < (base << k); p++) begin
        for (int i = 0; i < SUS_HALF; i++) begin
          e = '0; e.busy = 1; e.sx = 1; q.push_back(e);
        end
        for (int i = 0; i < SUS_HALF; i++) begin
          e = '0; e.busy = 1; e.sy = 1; q.push_back(e);
        end
      end
    end
    @(negedge clk);
    fs = 1'b0;
    if (poke_at > 0) begin
      repeat (poke_at) @(negedge clk);
      fs = 1'b1;
      base_cnt = BASE_W'(new_base);
      @(negedge clk);
      fs = 1'b0;
    end
    wait (q.size() == 0);
    repeat (3) @(negedge clk);
    check(busy_len == frame_len(base), tag, longint'(busy_len), longint'(frame_len(base)));
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    check(busy === 1'b0 && scan === '0 && reset_en === 1'b0, "R1 reset state",
          longint'({busy, reset_en}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_frame(1, 1, 0, 0, "R2 frame length base 1");
    run_frame(2, 7, 0, 0, "R6 frame length base 2");
    run_frame(0, 3, 0, 0, "R6 frame length base 0");
    run_frame(3, 11, 40, 3, "R8 start while busy ignored");
    run_frame(1, 5, 200, 9, "R7 base change mid-frame ignored");
    run_frame(1, 2, 1, 1, "R8 start right after accept ignored");
    repeat (5) @(negedge clk);
    check(busy === 1'b0, "R1 idle after final frame", longint'(busy), 0);
    summary();
  end
endmodule